// File: doc/BRIEF.md
# Multi-channel DMA register decoder

This block is the configuration bank for a chained-buffer DMA that has up to eight channels. Every channel is mapped into its own 4 KB window. For each channel the block holds the source and destination descriptor addresses, both buffer counts, one shared buffer size and the polling period. It decodes each 32-bit register access into a channel number and a register number, and it returns a registered response one cycle later.

Writing to a channel's run register sends a single-cycle start pulse or a single-cycle stop pulse to that channel's engine. Each engine reports a status code, and the block makes that code readable. An access that lands outside the decoded map returns an error response and changes nothing.

Top module: `dma_cfg_bank`

## Requirements
- R1: Address bits [14:12] give the channel and bits [4:0] give the register number. No other address bit changes the result of an access.
- R2: Every cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the next cycle. `rsp_valid` is low in every other cycle.
- R3: Register numbers 2 to 9 are read/write and return the last value written. The map is: 2 source descriptor low word, 3 source descriptor high word, 4 destination descriptor low word, 5 destination descriptor high word, 6 source buffer count, 7 destination buffer count, 8 buffer size (used by both sides), 9 polling period in cycles.
- R4: A written configuration value appears on the matching `cfg_*` output in the cycle after the write. Each output is a concatenation of per-channel fields, with channel 0 in the least significant position. Each descriptor address is 64 bits wide as {high word, low word}.
- R5: A write to register 0 (run) produces a one-cycle pulse for that channel in the response cycle. A non-zero value pulses `start_pulse`. A zero value pulses `stop_pulse`, whatever the channel's current status.
- R6: Reading register 0 returns zero. The write data and the `rsp_rdata` of any write response are zero.
- R7: Reading register 1 returns that channel's `eng_status` field, zero-extended. The field carries these codes: 0 idle, 1 source descriptor error, 2 destination descriptor error, 3 source data error, 4 destination data error, above 4 busy. A write to register 1 completes without error and has no effect.
- R8: An access to a register number from 10 to 31 returns `rsp_err` high and `rsp_rdata` zero. It changes no register and produces no pulse.
- R9: An access to a channel number at or above `NCH` returns the same error response and has no effect.
- R10: After reset, all configuration registers are zero, and there are no pulses and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_err | output | 1 | Access fell outside the decoded map |
| rsp_rdata | output | 32 | Read data |
| eng_status | input | NCH*STW | Status code of each channel engine |
| start_pulse | output | NCH | One-cycle start request per channel |
| stop_pulse | output | NCH | One-cycle abort request per channel |
| cfg_src_desc | output | NCH*64 | Source descriptor address per channel |
| cfg_dst_desc | output | NCH*64 | Destination descriptor address per channel |
| cfg_src_nbufs | output | NCH*32 | Source buffer count per channel |
| cfg_dst_nbufs | output | NCH*32 | Destination buffer count per channel |
| cfg_buf_size | output | NCH*32 | Buffer size per channel |
| cfg_period | output | NCH*32 | Polling period per channel |

## Verification
The embedded assertions check on every cycle the following properties:
- the response follows the request by exactly one cycle;
- an error response carries no data and no pulse;
- at most one pulse is raised at a time;
- the configuration outputs stay stable when no write happens.

Only the bench scenarios can show the rest:
- the correct decoding of channel and register from addresses that carry noise in the ignored bits;
- the readback of each register;
- the source of the status value;
- the fact that a status write or an out-of-map access leaves every register unchanged.

The bench compares all configuration outputs against its own model after every access.

// File: rtl/dma_cfg_bank.sv
module dma_cfg_bank #(
  parameter int NCH = 8,
  parameter int STW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [31:0]          req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [31:0]          rsp_rdata,
  input  logic [NCH*STW-1:0]   eng_status,
  output logic [NCH-1:0]       start_pulse,
  output logic [NCH-1:0]       stop_pulse,
  output logic [NCH*64-1:0]    cfg_src_desc,
  output logic [NCH*64-1:0]    cfg_dst_desc,
  output logic [NCH*32-1:0]    cfg_src_nbufs,
  output logic [NCH*32-1:0]    cfg_dst_nbufs,
  output logic [NCH*32-1:0]    cfg_buf_size,
  output logic [NCH*32-1:0]    cfg_period
);
  localparam logic [3:0] NCH_L = 4'(NCH);
  localparam logic [4:0] NREG  = 5'd10;

  logic [2:0]  ch;
  logic [4:0]  ri;
  logic        hit;
  logic [2:0]  cs;
  logic [31:0] rd;
  logic [31:0] cfg [NCH][2:9];

  assign ch  = req_addr[14:12];
  assign ri  = req_addr[4:0];
  assign hit = ({1'b0, ch} < NCH_L) && (ri < NREG);
  assign cs  = hit ? ch : 3'd0;

  always_comb begin
    rd = 32'd0;
    case (ri)
      5'd1: rd = {{(32-STW){1'b0}}, eng_status[cs*STW +: STW]};
      5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9: rd = cfg[cs][ri];
      default: rd = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 2; r <= 9; r++) cfg[c][r] <= 32'd0;
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_rdata   <= 32'd0;
      start_pulse <= '0;
      stop_pulse  <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_err     <= req_valid && !hit;
      rsp_rdata   <= (req_valid && hit && !req_write) ? rd : 32'd0;
      start_pulse <= '0;
      stop_pulse  <= '0;
      if (req_valid && req_write && hit) begin
        if (ri == 5'd0) begin
          if (req_wdata != 32'd0) start_pulse[cs] <= 1'b1;
          else                    stop_pulse[cs]  <= 1'b1;
        end else if (ri >= 5'd2) begin
          cfg[cs][ri] <= req_wdata;
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign cfg_src_desc[g*64 +: 64]  = {cfg[g][3], cfg[g][2]};
    assign cfg_dst_desc[g*64 +: 64]  = {cfg[g][5], cfg[g][4]};
    assign cfg_src_nbufs[g*32 +: 32] = cfg[g][6];
    assign cfg_dst_nbufs[g*32 +: 32] = cfg[g][7];
    assign cfg_buf_size[g*32 +: 32]  = cfg[g][8];
    assign cfg_period[g*32 +: 32]    = cfg[g][9];
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid)); // R2
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'd0)); // R8
  AST_ERR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (start_pulse == '0 && stop_pulse == '0)); // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({start_pulse, stop_pulse}) <= 1); // R5
  AST_PULSE_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse != '0 || stop_pulse != '0) |-> rsp_valid); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_write) |-> ($stable(cfg_src_desc) && $stable(cfg_period)
      && $stable(cfg_buf_size))); // R4
endmodule

// File: tb/test_dma_cfg_bank.sv
module test_dma_cfg_bank;
  localparam int PERIOD = 10;
  localparam int NCH = 6;
  localparam int STW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NCH*STW-1:0] eng_status = '0;
  logic [NCH-1:0] start_pulse, stop_pulse;
  logic [NCH*64-1:0] cfg_src_desc, cfg_dst_desc;
  logic [NCH*32-1:0] cfg_src_nbufs, cfg_dst_nbufs, cfg_buf_size, cfg_period;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m [NCH][10];

  always #(PERIOD/2) clk = ~clk;

  dma_cfg_bank #(.NCH(NCH), .STW(STW)) i_dma_cfg_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .eng_status(eng_status),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .cfg_src_desc(cfg_src_desc), .cfg_dst_desc(cfg_dst_desc),
    .cfg_src_nbufs(cfg_src_nbufs), .cfg_dst_nbufs(cfg_dst_nbufs),
    .cfg_buf_size(cfg_buf_size), .cfg_period(cfg_period));

  task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic check_cfg(string r);
    for (int g = 0; g < NCH; g++) begin
      chk(cfg_src_desc[g*64 +: 64] == {m[g][3], m[g][2]}, r, cfg_src_desc[g*64 +: 64], {m[g][3], m[g][2]});
      chk(cfg_dst_desc[g*64 +: 64] == {m[g][5], m[g][4]}, r, cfg_dst_desc[g*64 +: 64], {m[g][5], m[g][4]});
      chk(cfg_src_nbufs[g*32 +: 32] == m[g][6], r, 64'(cfg_src_nbufs[g*32 +: 32]), 64'(m[g][6]));
      chk(cfg_dst_nbufs[g*32 +: 32] == m[g][7], r, 64'(cfg_dst_nbufs[g*32 +: 32]), 64'(m[g][7]));
      chk(cfg_buf_size[g*32 +: 32] == m[g][8], r, 64'(cfg_buf_size[g*32 +: 32]), 64'(m[g][8]));
      chk(cfg_period[g*32 +: 32] == m[g][9], r, 64'(cfg_period[g*32 +: 32]), 64'(m[g][9]));
    end
  endtask

  task automatic acc(bit wr, logic [31:0] addr, logic [31:0] wd, string r);
    int c = int'(addr[14:12]);
    int ri = int'(addr[4:0]);
    bit ok = (c < NCH) && (ri < 10);
    logic [31:0] erd = 32'd0;
    logic [NCH-1:0] est = '0, esp = '0;
    @(negedge clk);
    eng_status = {NCH*STW/16{$urandom()}} ;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    if (ok && !wr && ri == 1) erd = {24'd0, eng_status[c*STW +: STW]};
    if (ok && !wr && ri >= 2) erd = m[c][ri];
    if (ok && wr && ri == 0) begin
      if (wd != 0) est[c] = 1'b1; else esp[c] = 1'b1;
    end
    if (ok && wr && ri >= 2) m[c][ri] = wd;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b1, {r, " R2 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_err == !ok, {r, " R8/R9 rsp_err"}, 64'(rsp_err), 64'(!ok));
    chk(rsp_rdata == erd, {r, " R1/R3/R6/R7 rdata"}, 64'(rsp_rdata), 64'(erd));
    chk(start_pulse == est, {r, " R5 start"}, 64'(start_pulse), 64'(est));
    chk(stop_pulse == esp, {r, " R5 stop"}, 64'(stop_pulse), 64'(esp));
    check_cfg({r, " R4 cfg"});
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, {r, " R2 idle"}, 64'(rsp_valid), 64'd0);
    chk(start_pulse == '0 && stop_pulse == '0, {r, " R5 one cycle"},
        64'({start_pulse, stop_pulse}), 64'd0);
  endtask

  function automatic logic [31:0] ad(int c, int r);
    return 32'((c << 12) | r);
  endfunction

  initial begin
    void'($urandom(32'd4321));
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 10; r++) m[c][r] = 32'd0;
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0 && start_pulse == '0 && stop_pulse == '0, "R10 reset outputs",
        64'({rsp_valid, start_pulse, stop_pulse}), 64'd0);
    check_cfg("R10 reset cfg");
    @(negedge clk); rst_n = 1'b1;

    for (int r = 2; r < 10; r++) acc(1'b1, ad(0, r), 32'hA500_0000 + 32'(r), "R3 write");
    for (int r = 2; r < 10; r++) acc(1'b0, ad(0, r), 32'd0, "R3 readback");
    acc(1'b1, ad(3, 0), 32'd1, "R5 run nonzero");
    acc(1'b1, ad(3, 0), 32'd0, "R5 run zero");
    acc(1'b0, ad(3, 0), 32'd0, "R6 run read");
    acc(1'b1, ad(2, 1), 32'hFFFF_FFFF, "R7 status write");
    acc(1'b0, ad(2, 1), 32'd0, "R7 status read");
    acc(1'b1, ad(1, 10), 32'h1234_5678, "R8 offset 10");
    acc(1'b1, ad(1, 31), 32'h1234_5678, "R8 offset 31");
    acc(1'b0, ad(1, 17), 32'd0, "R8 read offset 17");
    acc(1'b1, ad(NCH, 2), 32'hDEAD_BEEF, "R9 channel NCH");
    acc(1'b1, ad(7, 0), 32'd1, "R9 channel 7 run");
    acc(1'b1, 32'hFFFF_8FE5 & ~32'h0000_001A | 32'h0000_5005, 32'hCAFE_0001, "R1 noisy addr");
    acc(1'b0, ad(5, 5), 32'd0, "R1 noisy readback");

    for (int i = 0; i < 400; i++) begin
      int c = int'($urandom() % 8);
      int r = ($urandom() % 4 == 0) ? int'($urandom() % 32) : int'($urandom() % 10);
      logic [31:0] a = ($urandom() & ~32'h0000_701F) | ad(c, r);
      logic [31:0] w = ($urandom() % 5 == 0) ? 32'd0 : $urandom();
      acc(1'($urandom() % 2), a, w, "R1 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule